// File: doc/BRIEF.md
# USART Receiver with Entry-Tagged Status Buffer

This block is the receive side of a serial port that runs either asynchronously, timed by a 16x oversampling tick, or synchronously, timed by an external serial clock. It waits for a low start bit and then collects 5 to 9 data bits, least significant first. An optional parity bit follows, then a stop bit. Each finished character is written into a small first-in first-out buffer. Every buffer entry carries its own data, its ninth bit and its own error marks (framing, parity, overrun).

Software-side logic looks at the head entry through plain status and data outputs. A single read strobe discards the head. Because of this, the error marks and the ninth bit must be taken before the strobe is given. A ready flag shows that the buffer holds something, and an interrupt line follows that flag while it is enabled. Dropping the enable input clears the whole receiver.

Top module: `usart_rx_core`

## Requirements
- R1: In asynchronous mode (sync_mode=0, os_tick pulsing once per 1/16 bit), a low rx_in seen on a tick starts a frame only if rx_in is still low 8 ticks later. If it is high by then, the receiver drops back to idle and stores nothing. Each later bit is sampled 16 ticks after the previous sample.
- R2: Data bits arrive LSB first. size_code 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, 7 selects 9 bits, and 4 to 6 behave as 8 bits. rx_data holds bits 7:0 with unused upper bits at 0. rx_bit9 is the ninth bit in 9-bit mode and 0 otherwise.
- R3: With parity_en=1, one parity bit follows the data. err_parity is 1 when that bit differs from the XOR of the data bits XOR parity_odd, so parity_odd=0 checks even parity and parity_odd=1 checks odd parity. With parity_en=0, err_parity is 0.
- R4: err_frame is 1 when the first stop bit is sampled low, and the frame is still stored. A frame is complete at the first stop bit, so a new start bit may follow directly after it.
- R5: In synchronous mode (sync_mode=1), rx_in is sampled on each rising edge of xck when xck_fall=0, or on each falling edge when xck_fall=1. A low sample while idle is the start bit, with no mid-bit check.
- R6: The buffer holds two entries in arrival order. Data, ninth bit and error marks belong to each entry. A one-cycle rd_data pulse removes the head entry, and the head entry's outputs stay fixed until then.
- R7: rx_ready is 1 exactly when at least one entry is held. While it is 0, rx_data, rx_bit9 and all error outputs read 0.
- R8: A frame that completes while two entries are held and no read is given is dropped, and err_overrun is set on the newer held entry. Once an entry is read, the next frame is stored again.
- R9: A frame that completes in the same cycle as a read while the buffer is full is stored, and no overrun is marked.
- R10: While rx_en is 0 the buffer empties on the next clock edge, the receiver returns to idle, and incoming frames are not stored.
- R11: rx_irq is 1 exactly when rx_ready and irq_en are both 1.
- R12: A read pulse while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes buffer and idles the receiver |
| sync_mode | input | 1 | 1 = sample on serial clock edges, 0 = oversampled asynchronous |
| xck_fall | input | 1 | Synchronous mode sampling edge: 0 rising, 1 falling |
| xck | input | 1 | External serial clock, synchronous to clk |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| size_code | input | 3 | Character size select |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_in | input | 1 | Serial receive line, idle high |
| irq_en | input | 1 | Receive interrupt enable |
| rd_data | input | 1 | One-cycle read strobe; removes the head entry |
| rx_data | output | 8 | Head entry data bits 7:0 |
| rx_bit9 | output | 1 | Head entry ninth bit |
| err_frame | output | 1 | Head entry framing error |
| err_parity | output | 1 | Head entry parity error |
| err_overrun | output | 1 | Head entry overrun mark |
| rx_ready | output | 1 | Buffer holds at least one entry |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two events can land on the same clock edge: a character finishing its stop bit and a read strobe removing the head entry. This case matters most when the buffer is full. In synchronous mode the bench controls exactly which edge samples the stop bit, so it raises the read strobe together with that edge after checking the head entry. It then reads the two remaining entries and expects them in arrival order with no overrun mark. The plain overrun case, with no read given, is run separately for contrast.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] data;
        logic       fe;
        logic       pe;
        logic       ovr;
    } rx_entry_t;

    // Number of data bits chosen by a character-size code.
    function automatic logic [3:0] size_bits(input logic [2:0] code);
        case (code)
            3'd0:    size_bits = 4'd5;
            3'd1:    size_bits = 4'd6;
            3'd2:    size_bits = 4'd7;
            3'd7:    size_bits = 4'd9;
            default: size_bits = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/usart_rx_edge.sv
module usart_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic xck_fall,
    input  logic xck,
    output logic sync_stb
);
    typedef struct packed {
        logic xck_prev;
    } edge_state_t;

    edge_state_t q, d;

    always_comb begin
        d = q;
        d.xck_prev = xck;
        if (xck_fall) begin
            sync_stb = sync_mode && !xck && q.xck_prev;
        end else begin
            sync_stb = sync_mode && xck && !q.xck_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/usart_rx_deframe.sv
module usart_rx_deframe
    import usart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      sync_mode,
    input  logic      sync_stb,
    input  logic      os_tick,
    input  logic      rx_in,
    input  logic [2:0] size_code,
    input  logic      parity_en,
    input  logic      parity_odd,
    output logic      frm_valid,
    output rx_entry_t frm_entry
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OSR / 2 - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
        logic [8:0]    sh;
        logic          pbit;
    } deframe_state_t;

    deframe_state_t q, d;
    logic [3:0] nbits;
    logic       stb;

    always_comb begin
        d         = q;
        frm_valid = 1'b0;
        frm_entry = '0;
        nbits     = size_bits(size_code);
        stb       = sync_mode ? sync_stb : (os_tick && (q.cnt == CNT_LAST));

        // Oversampling counter runs in every bit-collecting state.
        if (!sync_mode && os_tick &&
            (q.st == ST_DATA || q.st == ST_PAR || q.st == ST_STOP)) begin
            d.cnt = (q.cnt == CNT_LAST) ? '0 : q.cnt + 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (sync_mode ? (sync_stb && !rx_in) : (os_tick && !rx_in)) begin
                    d.sh  = '0;
                    d.idx = '0;
                    d.cnt = '0;
                    d.st  = sync_mode ? ST_DATA : ST_START;
                end
            end
            ST_START: begin
                if (os_tick) begin
                    if (q.cnt == CNT_HALF) begin
                        d.cnt = '0;
                        d.st  = rx_in ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (stb) begin
                    if (q.idx < 4'd9) begin
                        d.sh[q.idx] = rx_in;
                    end
                    if (q.idx == nbits - 4'd1) begin
                        d.st = parity_en ? ST_PAR : ST_STOP;
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end
            end
            ST_PAR: begin
                if (stb) begin
                    d.pbit = rx_in;
                    d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (stb) begin
                    frm_valid     = 1'b1;
                    frm_entry.data = q.sh;
                    frm_entry.fe  = !rx_in;
                    frm_entry.pe  = parity_en && (q.pbit != ((^q.sh) ^ parity_odd));
                    frm_entry.ovr = 1'b0;
                    d.st          = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (!enable) begin
            d         = '0;
            d.st      = ST_IDLE;
            frm_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/usart_rx_fifo.sv
module usart_rx_fifo
    import usart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  rx_entry_t          push_entry,
    input  logic               pop,
    output rx_entry_t          head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [LW-1:0]         lvl;
    } fifo_state_t;

    fifo_state_t q, d;
    logic        do_pop;
    logic        room;
    logic [AW-1:0] newest;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        ptr_next = (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d      = q;
        do_pop = pop && (q.lvl != '0);
        room   = (q.lvl != LVL_FULL) || do_pop;
        newest = (q.wr == '0) ? PTR_LAST : q.wr - 1'b1;

        if (do_pop) begin
            d.rd = ptr_next(q.rd);
        end

        if (push && room) begin
            d.mem[q.wr] = push_entry;
            d.wr        = ptr_next(q.wr);
        end else if (push) begin
            d.mem[newest].ovr = 1'b1;
        end

        if ((push && room) && !do_pop) begin
            d.lvl = q.lvl + 1'b1;
        end else if (!(push && room) && do_pop) begin
            d.lvl = q.lvl - 1'b1;
        end

        if (flush) begin
            d = '0;
        end

        head  = (q.lvl != '0) ? q.mem[q.rd] : '0;
        level = q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/usart_rx_core.sv
module usart_rx_core
    import usart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       sync_mode,
    input  logic       xck_fall,
    input  logic       xck,
    input  logic       os_tick,
    input  logic [2:0] size_code,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       rx_in,
    input  logic       irq_en,
    input  logic       rd_data,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       rx_ready,
    output logic       rx_irq
);
    localparam int LW = $clog2(DEPTH + 1);

    logic          sync_stb;
    logic          frm_valid;
    rx_entry_t     frm_entry;
    rx_entry_t     head;
    logic [LW-1:0] fifo_level;

    usart_rx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_mode(sync_mode),
        .xck_fall (xck_fall),
        .xck      (xck),
        .sync_stb (sync_stb)
    );

    usart_rx_deframe #(.OSR(OSR)) u_deframe (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .sync_mode (sync_mode),
        .sync_stb  (sync_stb),
        .os_tick   (os_tick),
        .rx_in     (rx_in),
        .size_code (size_code),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .frm_valid (frm_valid),
        .frm_entry (frm_entry)
    );

    usart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_en),
        .push      (frm_valid),
        .push_entry(frm_entry),
        .pop       (rd_data),
        .head      (head),
        .level     (fifo_level)
    );

    always_comb begin
        rx_data     = head.data[7:0];
        rx_bit9     = head.data[8];
        err_frame   = head.fe;
        err_parity  = head.pe;
        err_overrun = head.ovr;
        rx_ready    = (fifo_level != '0);
        rx_irq      = rx_ready && irq_en;
    end
endmodule

// File: rtl/usart_rx_chk.sv
module usart_rx_chk #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic                       rd_data,
    input logic                       irq_en,
    input logic [7:0]                 rx_data,
    input logic                       rx_bit9,
    input logic                       err_frame,
    input logic                       err_parity,
    input logic                       err_overrun,
    input logic                       rx_ready,
    input logic                       rx_irq,
    input logic                       frm_valid,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready);

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= FULL);

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && rx_ready && !rd_data |=> !rx_en || (rx_ready && $stable(rx_data) && $stable(rx_bit9)));

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (rx_data == 8'd0 && !rx_bit9 && !err_frame && !err_parity && !err_overrun));

    assert_overrun_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && frm_valid && fifo_level == FULL && !rd_data |=> fifo_level == FULL);

    assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && frm_valid && fifo_level == FULL && rd_data |=> fifo_level == FULL);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !rx_irq);

    assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !rx_ready && rd_data && !frm_valid |=> !rx_ready);
endmodule

bind usart_rx_core usart_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_data    (rd_data),
    .irq_en     (irq_en),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_overrun(err_overrun),
    .rx_ready   (rx_ready),
    .rx_irq     (rx_irq),
    .frm_valid  (frm_valid),
    .fifo_level (fifo_level)
);

// File: tb/usart_rx_core_tb.sv
module usart_rx_core_tb;
    localparam int OSR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       sync_mode = 1'b0;
    logic       xck_fall = 1'b0;
    logic       xck = 1'b0;
    logic       os_tick = 1'b1;
    logic [2:0] size_code = 3'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rx_in = 1'b1;
    logic       irq_en = 1'b1;
    logic       rd_data = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, err_frame, err_parity, err_overrun, rx_ready, rx_irq;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    typedef struct {
        logic [8:0] d;
        logic       fe;
        logic       pe;
        logic       ovr;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    usart_rx_core #(.OSR(OSR), .DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode),
        .xck_fall(xck_fall), .xck(xck), .os_tick(os_tick), .size_code(size_code),
        .parity_en(parity_en), .parity_odd(parity_odd), .rx_in(rx_in),
        .irq_en(irq_en), .rd_data(rd_data), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .rx_ready(rx_ready), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        case (code)
            3'd0: return 5;
            3'd1: return 6;
            3'd2: return 7;
            3'd7: return 9;
            default: return 8;
        endcase
    endfunction

    // Driver side of the scoreboard: expected entry from requirements R2-R4.
    function automatic void exp_push(input logic [8:0] d, input logic pbit, input logic stopv);
        exp_t e;
        int   n = nbits_of(size_code);
        e.d   = d & 9'((1 << n) - 1);
        e.fe  = !stopv;
        e.pe  = parity_en && (pbit != ((^e.d) ^ parity_odd));
        e.ovr = 1'b0;
        sb.push_back(e);
    endfunction

    // Monitor side: compare head entry with the oldest expected item.
    task automatic compare_head(input string req);
        exp_t e;
        if (sb.size() == 0) begin
            check(req, "scoreboard empty", 32'd1, 32'd0);
            return;
        end
        e = sb.pop_front();
        check(req, "rx_ready", {31'd0, rx_ready}, 32'd1);
        check(req, "rx_data", {24'd0, rx_data}, {24'd0, e.d[7:0]});
        check(req, "rx_bit9", {31'd0, rx_bit9}, {31'd0, e.d[8]});
        check(req, "err_frame", {31'd0, err_frame}, {31'd0, e.fe});
        check(req, "err_parity", {31'd0, err_parity}, {31'd0, e.pe});
        check(req, "err_overrun", {31'd0, err_overrun}, {31'd0, e.ovr});
    endtask

    task automatic read_check(input string req);
        compare_head(req);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic send_frame(input logic [8:0] d, input logic pbit, input logic stopv,
                              input bit keep, input bit pop_at_stop);
        logic bits[$];
        int   n = nbits_of(size_code);
        bits.push_back(1'b0);
        for (int i = 0; i < n; i++) bits.push_back(d[i]);
        if (parity_en) bits.push_back(pbit);
        bits.push_back(stopv);
        for (int i = 0; i < bits.size(); i++) begin
            rx_in = bits[i];
            if (!sync_mode) begin
                repeat (OSR) @(negedge clk);
            end else begin
                xck = xck_fall;
                @(negedge clk);
                xck = ~xck_fall;
                if (pop_at_stop && i == bits.size() - 1) begin
                    compare_head("R9");
                    rd_data = 1'b1;
                end
                @(negedge clk);
                rd_data = 1'b0;
                @(negedge clk);
            end
        end
        rx_in = 1'b1;
        xck   = xck_fall;
        if (!stopv) repeat (OSR + 2) @(negedge clk);
        if (keep) exp_push(d, pbit, stopv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        check("R7", "ready after reset", {31'd0, rx_ready}, 32'd0);
        check("R7", "data after reset", {24'd0, rx_data}, 32'd0);
        check("R11", "irq after reset", {31'd0, rx_irq}, 32'd0);

        // R1 R2: basic 8-bit async frame, plus R11 irq follow
        send_frame(9'h0A5, 1'b0, 1'b1, 1, 0);
        @(negedge clk);
        check("R11", "irq with entry", {31'd0, rx_irq}, 32'd1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R11", "irq masked", {31'd0, rx_irq}, 32'd0);
        irq_en = 1'b1;
        read_check("R2");
        check("R7", "ready after drain", {31'd0, rx_ready}, 32'd0);
        check("R11", "irq after drain", {31'd0, rx_irq}, 32'd0);

        // R1: false start is rejected
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        check("R1", "false start stored nothing", {31'd0, rx_ready}, 32'd0);

        // R2: each size code
        size_code = 3'd0; send_frame(9'h015, 1'b0, 1'b1, 1, 0); read_check("R2");
        size_code = 3'd1; send_frame(9'h0EA, 1'b0, 1'b1, 1, 0); read_check("R2");
        size_code = 3'd2; send_frame(9'h1D5, 1'b0, 1'b1, 1, 0); read_check("R2");
        size_code = 3'd7; send_frame(9'h1A5, 1'b0, 1'b1, 1, 0); read_check("R2");
        size_code = 3'd5; send_frame(9'h1C3, 1'b0, 1'b1, 1, 0); read_check("R2");
        size_code = 3'd3;

        // R3: parity even / odd, good and bad
        parity_en = 1'b1; parity_odd = 1'b0;
        send_frame(9'h00F, 1'b0, 1'b1, 1, 0); read_check("R3");
        send_frame(9'h00F, 1'b1, 1'b1, 1, 0); read_check("R3");
        parity_odd = 1'b1;
        send_frame(9'h007, 1'b0, 1'b1, 1, 0); read_check("R3");
        send_frame(9'h007, 1'b1, 1'b1, 1, 0); read_check("R3");
        parity_en = 1'b0; parity_odd = 1'b0;

        // R4: bad stop bit, then back-to-back frames after a good stop
        send_frame(9'h03C, 1'b0, 1'b0, 1, 0); read_check("R4");
        send_frame(9'h011, 1'b0, 1'b1, 1, 0);
        send_frame(9'h022, 1'b0, 1'b1, 1, 0);
        @(negedge clk);
        read_check("R4");
        read_check("R6");

        // R8: overrun drops third frame and marks the newer entry
        send_frame(9'h0A1, 1'b0, 1'b1, 1, 0);
        send_frame(9'h0B2, 1'b0, 1'b1, 1, 0);
        send_frame(9'h0C3, 1'b0, 1'b1, 0, 0);
        sb[sb.size() - 1].ovr = 1'b1;
        @(negedge clk);
        read_check("R8");
        read_check("R8");
        check("R8", "dropped frame absent", {31'd0, rx_ready}, 32'd0);
        send_frame(9'h0D4, 1'b0, 1'b1, 1, 0);
        read_check("R8");

        // R5: synchronous mode, rising then falling sample edge
        sync_mode = 1'b1; xck_fall = 1'b0; xck = 1'b0;
        @(negedge clk);
        send_frame(9'h03C, 1'b0, 1'b1, 1, 0); read_check("R5");
        xck_fall = 1'b1; xck = 1'b1;
        @(negedge clk);
        send_frame(9'h0C5, 1'b0, 1'b1, 1, 0); read_check("R5");

        // R9: completion and read in the same cycle on a full buffer
        send_frame(9'h061, 1'b0, 1'b1, 1, 0);
        send_frame(9'h072, 1'b0, 1'b1, 1, 0);
        send_frame(9'h083, 1'b0, 1'b1, 1, 1);
        @(negedge clk);
        read_check("R9");
        read_check("R9");
        check("R9", "empty after both", {31'd0, rx_ready}, 32'd0);
        sync_mode = 1'b0; xck_fall = 1'b0; xck = 1'b0;
        @(negedge clk);

        // R10: disabling flushes; frames while disabled are not stored
        send_frame(9'h055, 1'b0, 1'b1, 0, 0);
        check("R10", "entry before flush", {31'd0, rx_ready}, 32'd1);
        rx_en = 1'b0;
        @(negedge clk);
        check("R10", "flushed", {31'd0, rx_ready}, 32'd0);
        send_frame(9'h066, 1'b0, 1'b1, 0, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R10", "no store while disabled", {31'd0, rx_ready}, 32'd0);

        // R12: read on empty buffer does nothing
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        check("R12", "still empty", {31'd0, rx_ready}, 32'd0);
        send_frame(9'h09E, 1'b0, 1'b1, 1, 0);
        read_check("R12");
        check("R12", "empty at end", {31'd0, rx_ready}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule